// File: doc/BRIEF.md
# Resynchronizable Sample-Rate Clock Generator

This block turns a fast input clock into a slower bit clock and a frame-sync pulse train for a serial port. The bit clock is a divided copy of the input clock. It comes with a one-cycle enable strobe that marks the last input-clock cycle of each divided period. Downstream logic that runs on the input clock uses that strobe to step once per bit.

Two modes choose where the frame timing comes from. In free-running mode the divider never stops. Frame pulses repeat every programmed number of divided-clock cycles and last a programmed width. In synchronized mode the block watches an external frame-sync pin through a two-stage synchronizer. Each inactive-to-active transition of that pin restarts the divider in its high phase and starts one generated frame pulse. The divided clock therefore stays phase-locked to an external device that divides the same input clock. In this mode the programmed period plays no part.

Top module: `srg_clkgen`

## Requirements
- R1: While `rst_ni` is low, `bclk_o` is 1 and `fsg_o` is 0, and both counters sit at their start values.
- R2: With no restart, `bclk_o` repeats with a period of `div_i`+1 input-clock cycles. It is high for the first ceil((`div_i`+1)/2) cycles of each period and low for the rest.
- R3: `bclk_en_o` is 1 in the last input-clock cycle of each divided period, so it recurs every `div_i`+1 cycles. With `div_i`=0 it is 1 in every cycle and `bclk_o` stays 1.
- R4: With `sync_en_i`=0, `fsg_o` is active (1) for `wid_i`+1 divided cycles at the start of every frame, and a frame lasts `per_i`+1 divided cycles. The first frame after reset starts at the first divided-period boundary.
- R5: With `sync_en_i`=1, suppose the pin change is first sampled at input-clock edge k. The divider restarts at edge k+2. From then on `bclk_o` is 1, `fsg_o` is 1, and a fresh divided period begins.
- R6: `fs_act_low_i`=0 makes the pin active-high (a rising edge triggers). `fs_act_low_i`=1 makes it active-low (a falling edge triggers). The opposite transition never triggers.
- R7: With `sync_en_i`=1, `per_i` has no effect. After its `wid_i`+1 divided cycles, `fsg_o` stays 0 until the next qualifying pin edge.
- R8: An active level held across only one input-clock edge triggers exactly one restart. An active level held for many cycles also triggers exactly one.
- R9: With `sync_en_i`=0, pin activity never changes the divider phase or the frame timing.
- R10: If a restart lands on the edge where the divider would wrap anyway, the divided clock and its strobe keep their spacing unchanged.
- R11: `wid_i`=0 gives a frame pulse exactly one divided cycle (`div_i`+1 input-clock cycles) long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_pin_i | input | 1 | External frame-sync pin, asynchronous |
| fs_act_low_i | input | 1 | 1: pin is active-low; 0: active-high |
| div_i | input | DIV_W | Divide value; period is div_i+1 input cycles |
| wid_i | input | WID_W | Frame pulse width minus one, in divided cycles |
| per_i | input | PER_W | Frame period minus one, in divided cycles (free mode) |
| sync_en_i | input | 1 | 1 selects synchronized mode |
| bclk_o | output | 1 | Divided clock |
| bclk_en_o | output | 1 | Strobe in the last input cycle of a divided period |
| fsg_o | output | 1 | Generated frame-sync pulse, active-high |

## Verification
A pin change that is first sampled at edge k reaches the outputs at edge k+2. The restarted `bclk_o` and `fsg_o` can therefore first be observed on the falling edge after k+2. The directed checks sample exactly there, and one falling edge earlier they confirm that nothing has moved yet. `bclk_en_o` and `fsg_o` also follow `div_i` and `wid_i` in the same cycle. For this reason inputs change just after a falling edge and outputs are compared on falling edges. A behavioural model steps on each rising edge and is compared on every falling edge, so divider and frame counts are checked continuously across each mode change.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // Polarity of the external frame-sync pin.
  typedef enum logic {
    FS_HIGH_ACTIVE = 1'b0,
    FS_LOW_ACTIVE  = 1'b1
  } fs_pol_e;
endpackage

// File: rtl/srg_fs_detect.sv
// Synchronizes the external frame-sync pin, applies polarity and
// flags an inactive-to-active transition when armed.
module srg_fs_detect
  import srg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic act_low_i,
  input  logic arm_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              act_q, act_d;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_comb begin
    level = sync_q[STAGES-1] ^ (fs_pol_e'(act_low_i) == FS_LOW_ACTIVE);
    act_d = level;
    evt_o = arm_i & level & ~act_q;
  end

  // act_q resets to "active" so a level present at reset is not an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      act_q  <= 1'b1;
    end else begin
      sync_q <= sync_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/srg_clk_div.sv
// Divide-by-(div+1) phase counter with a high-first output clock.
module srg_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             bclk_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   high_len;

  always_comb begin
    high_len = ({1'b0, div_i} + (DIV_W+1)'(2)) >> 1;
    bclk_o   = {1'b0, cnt_q} < high_len;
    tick_o   = cnt_q >= div_i;
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srg_frame_gen.sv
// Counts divided-clock cycles inside a frame. In hold mode the count
// saturates at IDLE instead of wrapping, so only a restart starts a frame.
module srg_frame_gen #(
  parameter int unsigned WID_W = 8,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [PER_W-1:0] per_i,
  output logic             fs_o
);
  localparam logic [PER_W-1:0] IDLE = '1;

  logic [PER_W-1:0] fcnt_q, fcnt_d;

  always_comb begin
    fcnt_d = fcnt_q;
    if (restart_i) begin
      fcnt_d = '0;
    end else if (tick_i) begin
      if (hold_i) fcnt_d = (fcnt_q == IDLE)  ? IDLE : fcnt_q + 1'b1;
      else        fcnt_d = (fcnt_q >= per_i) ? '0   : fcnt_q + 1'b1;
    end
    fs_o = fcnt_q <= {{(PER_W-WID_W){1'b0}}, wid_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcnt_q <= IDLE;
    else         fcnt_q <= fcnt_d;
  end
endmodule

// File: rtl/srg_clkgen.sv
module srg_clkgen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned WID_W       = 8,
  parameter int unsigned PER_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_pin_i,
  input  logic             fs_act_low_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             sync_en_i,
  output logic             bclk_o,
  output logic             bclk_en_o,
  output logic             fsg_o
);
  logic sync_evt;

  srg_fs_detect #(.STAGES(SYNC_STAGES)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (fs_pin_i),
    .act_low_i (fs_act_low_i),
    .arm_i     (sync_en_i),
    .evt_o     (sync_evt)
  );

  srg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_i),
    .restart_i (sync_evt),
    .bclk_o    (bclk_o),
    .tick_o    (bclk_en_o)
  );

  srg_frame_gen #(.WID_W(WID_W), .PER_W(PER_W)) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bclk_en_o),
    .restart_i (sync_evt),
    .hold_i    (sync_en_i),
    .wid_i     (wid_i),
    .per_i     (per_i),
    .fs_o      (fsg_o)
  );
endmodule

// File: rtl/srg_clkgen_chk.sv
module srg_clkgen_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned WID_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_en_i,
  input logic [DIV_W-1:0] div_i,
  input logic [WID_W-1:0] wid_i,
  input logic             sync_evt,
  input logic             bclk_o,
  input logic             bclk_en_o,
  input logic             fsg_o
);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (bclk_o && !fsg_o));

  p_restart_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt |=> (bclk_o && fsg_o));

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_en_o && !sync_evt && div_i != '0) |=> (!bclk_en_o || !$stable(div_i)));

  p_bclk_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bclk_o) && $stable(div_i) && !$past(sync_en_i)) |-> $past(bclk_en_o));

  p_no_free_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fsg_o) && $past(sync_en_i) && $stable(wid_i)) |-> $past(sync_evt));
endmodule

bind srg_clkgen srg_clkgen_chk #(.DIV_W(DIV_W), .WID_W(WID_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_en_i (sync_en_i),
  .div_i     (div_i),
  .wid_i     (wid_i),
  .sync_evt  (sync_evt),
  .bclk_o    (bclk_o),
  .bclk_en_o (bclk_en_o),
  .fsg_o     (fsg_o)
);

// File: tb/srg_clkgen_bench.sv
module srg_clkgen_bench;
  localparam int DIV_W = 8;
  localparam int WID_W = 8;
  localparam int PER_W = 12;
  localparam int FMAX  = (1 << PER_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic pin, pol, sync_en;
  logic [DIV_W-1:0] div;
  logic [WID_W-1:0] wid;
  logic [PER_W-1:0] per;
  logic bclk, bclk_en, fsg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  srg_clkgen #(.DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W)) u_srg_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .fs_pin_i(pin), .fs_act_low_i(pol),
    .div_i(div), .wid_i(wid), .per_i(per), .sync_en_i(sync_en),
    .bclk_o(bclk), .bclk_en_o(bclk_en), .fsg_o(fsg));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: integers stepped on every rising edge.
  int m_s1, m_s2, m_actp, m_cnt, m_fcnt;
  always @(posedge clk or negedge rst_n) begin : model
    int lvl, evt, wrap;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_actp = 1; m_cnt = 0; m_fcnt = FMAX;
    end else begin
      lvl  = m_s2 ^ int'(pol);
      evt  = (sync_en && lvl == 1 && m_actp == 0) ? 1 : 0;
      wrap = (m_cnt >= int'(div)) ? 1 : 0;
      if (evt == 1) m_fcnt = 0;
      else if (wrap == 1) begin
        if (sync_en) m_fcnt = (m_fcnt == FMAX) ? FMAX : m_fcnt + 1;
        else         m_fcnt = (m_fcnt >= int'(per)) ? 0 : m_fcnt + 1;
      end
      m_cnt  = (evt == 1 || wrap == 1) ? 0 : m_cnt + 1;
      m_actp = lvl;
      m_s2   = m_s1;
      m_s1   = int'(pin);
    end
  end

  always @(negedge clk) begin : compare
    int e_b, e_e, e_f;
    e_b = (m_cnt < (int'(div) + 2) / 2) ? 1 : 0;
    e_e = (m_cnt >= int'(div)) ? 1 : 0;
    e_f = (m_fcnt <= int'(wid)) ? 1 : 0;
    chk(int'(bclk) == e_b, "R2 model bclk", int'(bclk), e_b);
    chk(int'(bclk_en) == e_e, "R3 model bclk_en", int'(bclk_en), e_e);
    chk(int'(fsg) == e_f, "R4 model fsg", int'(fsg), e_f);
  end

  task automatic wait_rise_fsg();
    int prev = int'(fsg);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (fsg && prev == 0) return;
      prev = int'(fsg);
    end
  endtask

  task automatic count_rises(input int n, output int r);
    int prev = int'(fsg);
    r = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fsg && prev == 0) r++;
      prev = int'(fsg);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r, hi, last, gap_ok;
    rst_n = 1'b1; pin = 0; pol = 0; sync_en = 0;
    div = 8'd3; wid = 8'd1; per = 12'd4;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bclk == 1'b1, "R1 reset bclk", int'(bclk), 1);
    chk(fsg == 1'b0, "R1 reset fsg", int'(fsg), 0);
    #1 rst_n = 1'b1;

    // R4: free-running frames, period 5x4, width 2x4
    wait_rise_fsg();
    hi = 1;
    for (int i = 1; i < 200; i++) begin @(negedge clk); hi += int'(fsg); end
    chk(hi == 80, "R4 free frame high count", hi, 80);

    // R11: width zero gives one divided cycle
    #1 wid = 8'd0;
    wait_rise_fsg();
    hi = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (fsg) hi++; end
    chk(hi == 4, "R11 single-cycle frame width", hi, 4);

    // R9: pin activity ignored while sync is off
    #1 pin = 1;
    last = -1; gap_ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 10) begin #1 pin = 0; end
      if (bclk_en) begin
        if (last >= 0 && i - last != 4) gap_ok = 0;
        last = i;
      end
    end
    chk(gap_ok == 1, "R9 strobe spacing with sync off", gap_ok, 1);

    // R7: sync on, period ignored, no frames without edges
    #1 sync_en = 1; per = 12'd2; div = 8'd4;
    repeat (40) @(negedge clk);
    count_rises(60, r);
    chk(r == 0, "R7 no frame without pin edge", r, 0);

    // R5: restart timing and R2 pattern
    #1 pin = 1;
    @(negedge clk);
    @(negedge clk);
    chk(fsg == 1'b0, "R5 no restart before k+2", int'(fsg), 0);
    @(negedge clk);
    chk(fsg == 1'b1, "R5 frame starts at k+2", int'(fsg), 1);
    chk(bclk == 1'b1, "R5 bclk high after restart", int'(bclk), 1);
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      chk(int'(bclk) == (((i % 5) < 3) ? 1 : 0), "R2 bclk high-first pattern",
          int'(bclk), ((i % 5) < 3) ? 1 : 0);
    end

    // R8: long active level -> no further frames; one-cycle pulse -> one frame
    count_rises(60, r);
    chk(r == 0, "R8 long pulse gives one frame", r, 0);
    #1 pin = 0;
    repeat (5) @(negedge clk);
    #1 pin = 1;
    @(negedge clk);
    #1 pin = 0;
    count_rises(30, r);
    chk(r == 1, "R8 one-cycle pulse detected", r, 1);

    // R6: active-low polarity
    #1 sync_en = 0; pin = 1;
    repeat (5) @(negedge clk);
    #1 pol = 1;
    repeat (5) @(negedge clk);
    #1 sync_en = 1;
    repeat (30) @(negedge clk);
    #1 pin = 0;
    @(negedge clk);
    @(negedge clk);
    chk(fsg == 1'b0, "R6 falling edge not yet seen", int'(fsg), 0);
    @(negedge clk);
    chk(fsg == 1'b1, "R6 falling edge triggers when active-low", int'(fsg), 1);
    repeat (20) @(negedge clk);
    #1 pin = 1;
    count_rises(30, r);
    chk(r == 0, "R6 rising edge ignored when active-low", r, 0);

    // R10: restart landing on a natural wrap
    #1 div = 8'd3; pol = 0; pin = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (bclk_en) break; end
    @(negedge clk);
    @(negedge clk);
    #1 pin = 1;
    @(negedge clk);
    chk(bclk_en == 1'b0, "R10 strobe spacing kept (1)", int'(bclk_en), 0);
    @(negedge clk);
    chk(bclk_en == 1'b1, "R10 strobe on schedule", int'(bclk_en), 1);
    @(negedge clk);
    chk(fsg == 1'b1 && bclk == 1'b1, "R10 aligned restart fires frame",
        int'(fsg), 1);
    @(negedge clk); @(negedge clk);
    chk(bclk_en == 1'b0, "R10 no extra strobe", int'(bclk_en), 0);
    @(negedge clk);
    chk(bclk_en == 1'b1, "R10 next strobe after 4", int'(bclk_en), 1);

    // R3: divide by one
    #1 sync_en = 0; div = 8'd0;
    repeat (3) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bclk_en && bclk) hi++;
    end
    chk(hi == 10, "R3 div zero strobe every cycle", hi, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule